// File: doc/BRIEF.md
# Hysteretic Over-Temperature Alarm Unit

This block watches the stream of finished temperature conversions and turns it into an over-temperature alarm with hysteresis. Each time a conversion finishes, the result is compared as a signed number against a programmable upper threshold and a programmable lower threshold. The comparison uses quarter-degree granularity. Once the alarm is raised, it stays raised until a later result drops under the lower threshold or software pulses a clear strobe. If the clear arrives while the temperature is still hot, the alarm comes back on the next conversion.

The alarm drives a pin whose active level is selectable. A disable control forces the pin to its inactive level and forces the status bit to zero, but the internal alarm state is kept. Two sticky history flags record that the upper threshold was exceeded or that the temperature went below the lower threshold. Each flag is cleared only by a status read that comes after its condition has ended. Bus decoding and the converter itself lie outside the block. Threshold writes and the status-read strobe arrive already decoded.

Top module: `otw_alarm_unit`

## Requirements
- R1: On a cycle with `conv_done` high, the alarm becomes active when the result, with its bits 4:0 treated as zero, is strictly greater than the upper threshold.
- R2: A completed result strictly below the lower threshold makes the alarm inactive. A result from the lower threshold up to the upper threshold inclusive leaves the alarm state unchanged.
- R3: A one-cycle `alarm_clr` pulse makes the alarm inactive. If the next completed result is still above the upper threshold, the alarm becomes active again.
- R4: A threshold write keeps `wr_data[15:5]` and reads back with bits 4:0 equal to zero. After reset, the upper threshold reads 16'h4880 and the lower threshold reads 16'h4600.
- R5: The pin level equals the effective alarm when `cfg_pol` is 1 (active-high) and its inverse when `cfg_pol` is 0 (active-low). After reset, with `cfg_pol` at 0, the pin reads 1.
- R6: While `cfg_dis` is 1, the pin sits at its inactive level and `alarm_status` is 0. The alarm state is retained, so clearing `cfg_dis` shows it again without a new conversion.
- R7: `flag_hi` sets on a completed result above the upper threshold. It clears only on a `status_rd` pulse while the most recent result was not above that threshold.
- R8: `flag_lo` sets on a completed result below the lower threshold. It clears only on a `status_rd` pulse while the most recent result was not below that threshold.
- R9: The alarm state and the flags update at the clock edge that samples `conv_done`. `alarm_pin` and `alarm_status` follow one clock later.
- R10: All comparisons are two's-complement signed, so a negative result counts as below a positive lower threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse: `conv_result` holds a new value |
| conv_result | input | 16 | Signed conversion result, 1/128 °C per LSB |
| hi_wr | input | 1 | Write strobe for the upper threshold |
| lo_wr | input | 1 | Write strobe for the lower threshold |
| wr_data | input | 16 | Threshold write data |
| cfg_dis | input | 1 | 1 forces the alarm output off |
| cfg_pol | input | 1 | 1 makes the pin active-high, 0 active-low |
| alarm_clr | input | 1 | One-cycle software clear of the alarm |
| status_rd | input | 1 | One-cycle pulse marking a status register read |
| hi_lim_q | output | 16 | Upper threshold readback |
| lo_lim_q | output | 16 | Lower threshold readback |
| alarm_pin | output | 1 | Alarm pin level |
| alarm_status | output | 1 | Effective alarm (pin asserted) |
| flag_hi | output | 1 | Sticky above-upper-threshold flag |
| flag_lo | output | 1 | Sticky below-lower-threshold flag |

## Verification
The assertions assume that `conv_done`, `alarm_clr` and `status_rd` are single-cycle strobes. They also assume that the thresholds are not written in the same cycle as a conversion, so the comparison seen at an edge uses stable limits. The stimulus drives every strobe for exactly one clock, on the falling edge. It keeps threshold writes, clears and status reads apart from conversion pulses. It changes `cfg_pol` and `cfg_dis` only between conversions, so each output check sees one cause at a time.

// File: rtl/otw_pkg.sv
package otw_pkg;
  typedef struct packed {
    logic above;
    logic below;
  } otw_cmp_t;
endpackage

// File: rtl/otw_limit_reg.sv
module otw_limit_reg #(
  parameter int W = 16,
  parameter int DROP = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam int KEEP = W - DROP;
  logic [KEEP-1:0] store;

  always_ff @(posedge clk) begin
    if (rst) store <= RST_VAL[W-1:DROP];
    else if (wr) store <= wdata[W-1:DROP];
  end

  assign q = {store, {DROP{1'b0}}};

  assert_limit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
  assert_limit_load_R4: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q[W-1:DROP] == $past(wdata[W-1:DROP])));
endmodule

// File: rtl/otw_compare.sv
module otw_compare
  import otw_pkg::*;
#(
  parameter int W = 16,
  parameter int DROP = 5
) (
  input  logic [W-1:0] result,
  input  logic [W-1:0] hi_lim,
  input  logic [W-1:0] lo_lim,
  output otw_cmp_t     cmp
);
  localparam int KEEP = W - DROP;
  logic signed [W-1:0] t_s, hi_s, lo_s;

  assign t_s  = {result[W-1:DROP], {DROP{1'b0}}};
  assign hi_s = hi_lim;
  assign lo_s = lo_lim;

  always_comb begin
    cmp.above = (t_s > hi_s);
    cmp.below = (t_s < lo_s);
  end

  always_comb begin
    if ((hi_s >= lo_s) && cmp.above)
      assert_cmp_exclusive_R10: assert (!cmp.below);
  end
endmodule

// File: rtl/otw_alarm_core.sv
module otw_alarm_core
  import otw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     conv_done,
  input  otw_cmp_t cmp,
  input  logic     alarm_clr,
  input  logic     status_rd,
  input  logic     cfg_dis,
  input  logic     cfg_pol,
  output logic     alarm_pin,
  output logic     alarm_status,
  output logic     flag_hi,
  output logic     flag_lo
);
  logic alarm_st;
  logic hi_cond, lo_cond;
  logic eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_st <= 1'b0;
    end else if (conv_done) begin
      if (cmp.above) alarm_st <= 1'b1;
      else if (cmp.below) alarm_st <= 1'b0;
      else if (alarm_clr) alarm_st <= 1'b0;
    end else if (alarm_clr) begin
      alarm_st <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cond <= 1'b0;
      lo_cond <= 1'b0;
    end else if (conv_done) begin
      hi_cond <= cmp.above;
      lo_cond <= cmp.below;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else begin
      if (conv_done && cmp.above) flag_hi <= 1'b1;
      else if (status_rd && !hi_cond) flag_hi <= 1'b0;
      if (conv_done && cmp.below) flag_lo <= 1'b1;
      else if (status_rd && !lo_cond) flag_lo <= 1'b0;
    end
  end

  assign eff = alarm_st & ~cfg_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_status <= 1'b0;
      alarm_pin    <= 1'b1;
    end else begin
      alarm_status <= eff;
      alarm_pin    <= cfg_pol ? eff : ~eff;
    end
  end

  assert_set_above_R1: assert property (@(posedge clk) disable iff (rst)
    (conv_done && cmp.above) |=> alarm_st);
  assert_clear_below_R2: assert property (@(posedge clk) disable iff (rst)
    (conv_done && cmp.below) |=> !alarm_st);
  assert_sw_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (alarm_clr && !conv_done) |=> !alarm_st);
  assert_pin_off_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_dis |=> (!alarm_status && (alarm_pin == !$past(cfg_pol))));
  assert_hi_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_hi) |-> $past(status_rd));
  assert_lo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_lo) |-> $past(status_rd));
  assert_status_lag_R9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_dis && $rose(alarm_st)) |=> alarm_status);
endmodule

// File: rtl/otw_alarm_unit.sv
module otw_alarm_unit
  import otw_pkg::*;
#(
  parameter int W = 16,
  parameter int DROP = 5,
  parameter logic [W-1:0] HI_RST = 16'h4880,
  parameter logic [W-1:0] LO_RST = 16'h4600
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  input  logic         hi_wr,
  input  logic         lo_wr,
  input  logic [W-1:0] wr_data,
  input  logic         cfg_dis,
  input  logic         cfg_pol,
  input  logic         alarm_clr,
  input  logic         status_rd,
  output logic [W-1:0] hi_lim_q,
  output logic [W-1:0] lo_lim_q,
  output logic         alarm_pin,
  output logic         alarm_status,
  output logic         flag_hi,
  output logic         flag_lo
);
  otw_cmp_t cmp;

  otw_limit_reg #(.W(W), .DROP(DROP), .RST_VAL(HI_RST)) u_hi_lim (
    .clk(clk), .rst(rst), .wr(hi_wr), .wdata(wr_data), .q(hi_lim_q));

  otw_limit_reg #(.W(W), .DROP(DROP), .RST_VAL(LO_RST)) u_lo_lim (
    .clk(clk), .rst(rst), .wr(lo_wr), .wdata(wr_data), .q(lo_lim_q));

  otw_compare #(.W(W), .DROP(DROP)) u_cmp (
    .result(conv_result), .hi_lim(hi_lim_q), .lo_lim(lo_lim_q), .cmp(cmp));

  otw_alarm_core u_core (
    .clk(clk), .rst(rst), .conv_done(conv_done), .cmp(cmp),
    .alarm_clr(alarm_clr), .status_rd(status_rd),
    .cfg_dis(cfg_dis), .cfg_pol(cfg_pol),
    .alarm_pin(alarm_pin), .alarm_status(alarm_status),
    .flag_hi(flag_hi), .flag_lo(flag_lo));
endmodule

// File: tb/otw_alarm_unit_tb.sv
module otw_alarm_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_done = 1'b0;
  logic [15:0] conv_result = '0;
  logic hi_wr = 1'b0, lo_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic cfg_dis = 1'b0, cfg_pol = 1'b0;
  logic alarm_clr = 1'b0, status_rd = 1'b0;
  logic [15:0] hi_lim_q, lo_lim_q;
  logic alarm_pin, alarm_status, flag_hi, flag_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otw_alarm_unit u_dut (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .hi_wr(hi_wr), .lo_wr(lo_wr), .wr_data(wr_data),
    .cfg_dis(cfg_dis), .cfg_pol(cfg_pol), .alarm_clr(alarm_clr),
    .status_rd(status_rd), .hi_lim_q(hi_lim_q), .lo_lim_q(lo_lim_q),
    .alarm_pin(alarm_pin), .alarm_status(alarm_status),
    .flag_hi(flag_hi), .flag_lo(flag_lo));

  // {result, status, flag_hi, flag_lo} under default limits, cfg_pol=0
  localparam logic [18:0] VEC [8] = '{
    {16'h0C80, 1'b0, 1'b0, 1'b1},
    {16'h4700, 1'b0, 1'b0, 1'b1},
    {16'h489F, 1'b0, 1'b0, 1'b1},
    {16'h48A0, 1'b1, 1'b1, 1'b1},
    {16'h4700, 1'b1, 1'b1, 1'b1},
    {16'h45E0, 1'b0, 1'b1, 1'b1},
    {16'hEC00, 1'b0, 1'b1, 1'b1},
    {16'h7FE0, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [15:0] v);
    @(negedge clk); conv_done = 1'b1; conv_result = v;
    @(negedge clk); conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_lim(input bit hi, input logic [15:0] d);
    @(negedge clk); wr_data = d; hi_wr = hi; lo_wr = !hi;
    @(negedge clk); hi_wr = 1'b0; lo_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4/R5 reset state
    chk("R4 hi reset", hi_lim_q, 16'h4880);
    chk("R4 lo reset", lo_lim_q, 16'h4600);
    chk("R5 pin reset", {15'd0, alarm_pin}, 16'd1);
    chk("R6 status reset", {15'd0, alarm_status}, 16'd0);
    chk("R7 flag_hi reset", {15'd0, flag_hi}, 16'd0);
    chk("R8 flag_lo reset", {15'd0, flag_lo}, 16'd0);

    // R1 R2 R10: table walk
    for (int i = 0; i < 8; i++) begin
      conv(VEC[i][18:3]);
      chk("R1/R2/R10 status", {15'd0, alarm_status}, {15'd0, VEC[i][2]});
      chk("R5 pin active-low", {15'd0, alarm_pin}, {15'd0, !VEC[i][2]});
      chk("R7 flag_hi", {15'd0, flag_hi}, {15'd0, VEC[i][1]});
      chk("R8 flag_lo", {15'd0, flag_lo}, {15'd0, VEC[i][0]});
    end

    // R7 R8: read clears only ended conditions
    pulse_rd();
    chk("R7 hi kept while above", {15'd0, flag_hi}, 16'd1);
    chk("R8 lo cleared after end", {15'd0, flag_lo}, 16'd0);
    conv(16'h4700);
    chk("R7 hi kept without read", {15'd0, flag_hi}, 16'd1);
    pulse_rd();
    chk("R7 hi cleared by read", {15'd0, flag_hi}, 16'd0);
    chk("R2 hold between limits", {15'd0, alarm_status}, 16'd1);

    // R3 software clear and re-assert
    pulse_clr();
    chk("R3 cleared", {15'd0, alarm_status}, 16'd0);
    chk("R3 pin inactive", {15'd0, alarm_pin}, 16'd1);
    conv(16'h7FE0);
    chk("R3 re-assert", {15'd0, alarm_status}, 16'd1);

    // R5 polarity
    @(negedge clk); cfg_pol = 1'b1;
    @(negedge clk);
    chk("R5 active-high pin", {15'd0, alarm_pin}, 16'd1);

    // R6 disable
    @(negedge clk); cfg_dis = 1'b1;
    @(negedge clk);
    chk("R6 pin off", {15'd0, alarm_pin}, 16'd0);
    chk("R6 status off", {15'd0, alarm_status}, 16'd0);
    @(negedge clk); cfg_dis = 1'b0;
    @(negedge clk);
    chk("R6 state kept", {15'd0, alarm_status}, 16'd1);
    chk("R6 pin back", {15'd0, alarm_pin}, 16'd1);

    // R4 limit writes
    wr_lim(1'b1, 16'h1234);
    wr_lim(1'b0, 16'h0FFF);
    chk("R4 hi low bits", hi_lim_q, 16'h1220);
    chk("R4 lo low bits", lo_lim_q, 16'h0FE0);
    conv(16'h123F);
    chk("R1 equal not above", {15'd0, alarm_status}, 16'd1);
    conv(16'h0FC0);
    chk("R2 below new lo", {15'd0, alarm_status}, 16'd0);
    pulse_rd();
    chk("R7 hi cleared", {15'd0, flag_hi}, 16'd0);
    chk("R8 lo still below", {15'd0, flag_lo}, 16'd1);

    // R9 latency
    @(negedge clk); conv_done = 1'b1; conv_result = 16'h1240;
    @(posedge clk); #2;
    conv_done = 1'b0;
    chk("R9 flag same edge", {15'd0, flag_hi}, 16'd1);
    chk("R9 status not yet", {15'd0, alarm_status}, 16'd0);
    @(posedge clk); #2;
    chk("R9 status next edge", {15'd0, alarm_status}, 16'd1);
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule